// File: doc/BRIEF.md
# Output Protection and Diagnostic Supervisor

This block sits between the latched per-channel on/off commands of an isolated eight-way high-side switch and the enables that actually drive the power stages. Each clock it reads a digitized junction temperature for every channel, a digitized output-supply code, a strobe that marks the end of each transfer across the isolation link with a flag saying whether that transfer was judged sound, and a signal saying that the command-side domain has settled. From these it decides which channels may conduct.

Three independent cut-offs apply. The first is a per-channel thermal latch with a hysteresis band. The second is a global supply-undervoltage latch with a higher restart threshold. The third is a saturating count of consecutive bad link transfers, which forces every output off until a good transfer arrives. A common active-low diagnostic flag reports any thermal trip or undervoltage. Enables and the flag are registered and follow their inputs by one clock.

Top module: `prot_supervisor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_en` is all zero and `diag_n` is 0. No channel is tripped, the bad-transfer count is zero, and the supply is treated as under-voltage until a code at or above the restart threshold is seen.
- R2: When the temperature code of channel i (bits [i*TEMP_W +: TEMP_W] of `temp_bus`) is strictly above HOT_TRIP (default 135) at a clock edge, bit i of `out_en` is 0 after that edge. The other channels are unaffected.
- R3: A tripped channel stays tripped while its code is above HOT_RELEASE (default 125). It is released at the first edge where its code is at or below HOT_RELEASE. A code equal to HOT_TRIP does not trip.
- R4: `diag_n` is 0 after an edge at which any channel is tripped or the supply is under-voltage. Otherwise it is 1. Link failure and `input_stable` do not affect it.
- R5: A supply code strictly below UV_OFF (default 70) at an edge sets the under-voltage state, and all of `out_en` is 0 after that edge.
- R6: The under-voltage state clears only at an edge where the supply code is at or above UV_ON (default 110). Codes between the two thresholds keep the present state.
- R7: Each edge with `link_strobe`=1 and `link_valid`=0 adds one to a bad-transfer count that saturates at FAIL_LIMIT (default 4). While the count equals FAIL_LIMIT, all of `out_en` is 0. Fewer bad transfers have no effect on the enables.
- R8: An edge with `link_strobe`=1 and `link_valid`=1 clears the count and lifts the link cut-off at that edge. `link_valid` is ignored when `link_strobe` is 0.
- R9: While `input_stable` is 0 at an edge, all of `out_en` is 0 after it. Thermal, supply and link state keep evolving as usual.
- R10: Bit i of `out_en` is 1 after an edge exactly when, at that edge, `cmd` bit i is 1, channel i is not tripped, the supply is not under-voltage, the count is below FAIL_LIMIT, and `input_stable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | NCH | Latched channel commands, bit i = channel i |
| temp_bus | input | NCH*TEMP_W | Junction temperature codes, channel i at [i*TEMP_W +: TEMP_W] |
| vsup | input | VSUP_W | Output-supply voltage code |
| link_strobe | input | 1 | One per completed isolation-link transfer |
| link_valid | input | 1 | Transfer judged sound, read only with the strobe |
| input_stable | input | 1 | Command-side domain settled |
| out_en | output | NCH | Gated channel enables |
| diag_n | output | 1 | Active-low common diagnostic |

## Verification
The bench drives temperatures onto and just around both thermal thresholds. A design that tripped at equality, released one code early, or let one hot channel drag its neighbours off would diverge from the model. It walks the supply code through 69, 70, 109 and 110 in both directions, which exposes a missing or inverted hysteresis band. It sends three bad transfers, then a fourth, then more, and then a good flag without a strobe. An off-by-one limit, a counter that wraps instead of saturating, or one that clears without a strobe all show up as wrong enables. A long random phase mixes all cut-offs with `input_stable` drops, to catch gating that also corrupts held state.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Thermal latch state of one channel
    typedef enum logic {
        TH_COOL = 1'b0,
        TH_HOT  = 1'b1
    } therm_e;

    // Global cut-off reasons shared by all channels
    typedef struct packed {
        logic uv;
        logic link;
        logic unstable;
    } glob_cut_t;

    function automatic logic any_cut(input glob_cut_t c);
        return c.uv | c.link | c.unstable;
    endfunction

endpackage

// File: rtl/sup_thermal_chan.sv
module sup_thermal_chan
    import sup_pkg::*;
#(
    parameter int              TW      = 8,
    parameter logic [TW-1:0]   T_TRIP  = 8'd135,
    parameter logic [TW-1:0]   T_REL   = 8'd125
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp,
    output logic          hot_d,
    output logic          hot_q
);

    therm_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (temp > T_TRIP)
            st_d = TH_HOT;
        else if (temp <= T_REL)
            st_d = TH_COOL;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TH_COOL;
        else     st_q <= st_d;
    end

    assign hot_d = (st_d == TH_HOT);
    assign hot_q = (st_q == TH_HOT);

    AST_TRIP_ON_HOT: assert property (@(posedge clk) disable iff (rst)
        (temp > T_TRIP) |=> hot_q); // R2
    AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (rst)
        (hot_q && temp > T_REL) |=> hot_q); // R3
    AST_RELEASE_COOL: assert property (@(posedge clk) disable iff (rst)
        (temp <= T_REL) |=> !hot_q); // R3

endmodule

// File: rtl/sup_uv_mon.sv
module sup_uv_mon #(
    parameter int            VW    = 8,
    parameter logic [VW-1:0] V_OFF = 8'd70,
    parameter logic [VW-1:0] V_ON  = 8'd110
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vsup,
    output logic          uv_d,
    output logic          uv_q
);

    always_comb begin
        uv_d = uv_q;
        if (vsup < V_OFF)
            uv_d = 1'b1;
        else if (vsup >= V_ON)
            uv_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) uv_q <= 1'b1;
        else     uv_q <= uv_d;
    end

    AST_UV_SET: assert property (@(posedge clk) disable iff (rst)
        (vsup < V_OFF) |=> uv_q); // R5
    AST_UV_STAYS_OK: assert property (@(posedge clk) disable iff (rst)
        (!uv_q && vsup >= V_OFF) |=> !uv_q); // R6
    AST_UV_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        (uv_q && vsup < V_ON) |=> uv_q); // R6

endmodule

// File: rtl/sup_link_watch.sv
module sup_link_watch #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic valid,
    output logic fail_d,
    output logic fail_q
);

    localparam int          CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (strobe) begin
            if (valid)
                cnt_d = '0;
            else if (cnt_q != LIM_C)
                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign fail_d = (cnt_d == LIM_C);
    assign fail_q = (cnt_q == LIM_C);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM_C); // R7
    AST_GOOD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (strobe && valid) |=> (cnt_q == '0)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
    import sup_pkg::*;
#(
    parameter int                  NCH         = 8,
    parameter int                  TEMP_W      = 8,
    parameter int                  VSUP_W      = 8,
    parameter logic [TEMP_W-1:0]   HOT_TRIP    = 8'd135,
    parameter logic [TEMP_W-1:0]   HOT_RELEASE = 8'd125,
    parameter logic [VSUP_W-1:0]   UV_OFF      = 8'd70,
    parameter logic [VSUP_W-1:0]   UV_ON       = 8'd110,
    parameter int                  FAIL_LIMIT  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          cmd,
    input  logic [NCH*TEMP_W-1:0]   temp_bus,
    input  logic [VSUP_W-1:0]       vsup,
    input  logic                    link_strobe,
    input  logic                    link_valid,
    input  logic                    input_stable,
    output logic [NCH-1:0]          out_en,
    output logic                    diag_n
);

    logic [NCH-1:0] hot_d, hot_q;
    logic           uv_d, uv_q;
    logic           fail_d, fail_q;
    glob_cut_t      cut;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        sup_thermal_chan #(
            .TW     (TEMP_W),
            .T_TRIP (HOT_TRIP),
            .T_REL  (HOT_RELEASE)
        ) u_th (
            .clk   (clk),
            .rst   (rst),
            .temp  (temp_bus[i*TEMP_W +: TEMP_W]),
            .hot_d (hot_d[i]),
            .hot_q (hot_q[i])
        );
    end

    sup_uv_mon #(
        .VW    (VSUP_W),
        .V_OFF (UV_OFF),
        .V_ON  (UV_ON)
    ) u_uv (
        .clk  (clk),
        .rst  (rst),
        .vsup (vsup),
        .uv_d (uv_d),
        .uv_q (uv_q)
    );

    sup_link_watch #(
        .LIMIT (FAIL_LIMIT)
    ) u_link (
        .clk    (clk),
        .rst    (rst),
        .strobe (link_strobe),
        .valid  (link_valid),
        .fail_d (fail_d),
        .fail_q (fail_q)
    );

    always_comb begin
        cut.uv       = uv_d;
        cut.link     = fail_d;
        cut.unstable = ~input_stable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_en <= '0;
            diag_n <= 1'b0;
        end else begin
            out_en <= any_cut(cut) ? '0 : (cmd & ~hot_d);
            diag_n <= ~((|hot_d) | uv_d);
        end
    end

    AST_DIAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
        diag_n == !((|hot_q) || uv_q)); // R4
    AST_HOT_CUT: assert property (@(posedge clk) disable iff (rst)
        (out_en & hot_q) == '0); // R2
    AST_UV_CUT: assert property (@(posedge clk) disable iff (rst)
        uv_q |-> (out_en == '0)); // R5
    AST_LINK_CUT: assert property (@(posedge clk) disable iff (rst)
        fail_q |-> (out_en == '0)); // R7
    AST_STABLE_GATE: assert property (@(posedge clk) disable iff (rst)
        !input_stable |=> (out_en == '0)); // R9
    AST_EN_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((out_en & ~$past(cmd)) == '0)); // R10

endmodule

// File: tb/prot_supervisor_bench.sv
module prot_supervisor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] cmd = '0;
    logic [63:0]    temp_bus;
    logic [7:0]     vsup = 8'd0;
    logic           link_strobe = 1'b0;
    logic           link_valid = 1'b0;
    logic           input_stable = 1'b0;
    logic [NCH-1:0] out_en;
    logic           diag_n;

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    int trip_m [NCH];
    int uv_m;
    int cnt_m;
    int en_m;
    int diag_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_supervisor u_prot_supervisor (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .temp_bus     (temp_bus),
        .vsup         (vsup),
        .link_strobe  (link_strobe),
        .link_valid   (link_valid),
        .input_stable (input_stable),
        .out_en       (out_en),
        .diag_n       (diag_n)
    );

    task automatic model_step();
        int any;
        if (rst) begin
            for (int i = 0; i < NCH; i++) trip_m[i] = 0;
            uv_m = 1; cnt_m = 0; en_m = 0; diag_m = 0;
            return;
        end
        any = 0;
        for (int i = 0; i < NCH; i++) begin
            int t;
            t = int'(temp_bus[i*8 +: 8]);
            if (t > 135) trip_m[i] = 1;
            else if (t <= 125) trip_m[i] = 0;
            if (trip_m[i] != 0) any = 1;
        end
        if (int'(vsup) < 70) uv_m = 1;
        else if (int'(vsup) >= 110) uv_m = 0;
        if (link_strobe) begin
            if (link_valid) cnt_m = 0;
            else if (cnt_m < 4) cnt_m = cnt_m + 1;
        end
        en_m = 0;
        if (input_stable && uv_m == 0 && cnt_m < 4)
            for (int i = 0; i < NCH; i++)
                if (cmd[i] && trip_m[i] == 0) en_m = en_m | (1 << i);
        diag_m = (any != 0 || uv_m != 0) ? 0 : 1;
    endtask

    // one clock: edge, model update, compare well after the edge
    task automatic cyc();
        @(posedge clk);
        #1;
        model_step();
        compared++;
        if (int'(out_en) != en_m || int'(diag_n) != diag_m) begin
            mismatched++;
            $display("FAIL %s t=%0t out_en=%02h exp=%02h diag_n=%0d exp=%0d",
                     tag, $time, out_en, en_m[7:0], diag_n, diag_m);
        end
    endtask

    task automatic set_temp(input int ch, input int val);
        temp_bus[ch*8 +: 8] = 8'(val);
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic strobe(input bit v);
        link_strobe = 1'b1; link_valid = v;
        cyc();
        link_strobe = 1'b0; link_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) temp_bus[i*8 +: 8] = 8'd50;
        // R1: reset state
        tag = "R1";
        cmd = 8'hFF; vsup = 8'd120; input_stable = 1'b1;
        cycles(3);
        rst = 1'b0;
        vsup = 8'd0;
        cycles(2);
        // R10: basic gating with several command patterns
        tag = "R10";
        vsup = 8'd120;
        cmd = 8'hFF; cycles(2);
        cmd = 8'hA5; cycles(2);
        cmd = 8'h3C; cycles(1);
        cmd = 8'h00; cycles(1);
        cmd = 8'hFF; cycles(1);
        // R2/R3: thermal thresholds on channel 3
        tag = "R3"; set_temp(3, 135); cycles(2);
        tag = "R2"; set_temp(3, 136); cycles(2);
        tag = "R4"; cycles(1);
        tag = "R3"; set_temp(3, 130); cycles(2);
        set_temp(3, 126); cycles(1);
        set_temp(3, 125); cycles(2);
        // R2: two channels at the edges of the bus
        tag = "R2"; set_temp(0, 200); set_temp(7, 255); cycles(2);
        set_temp(0, 50); cycles(1);
        set_temp(7, 100); cycles(2);
        // R5/R6: undervoltage hysteresis
        tag = "R6"; vsup = 8'd70; cycles(1);
        tag = "R5"; vsup = 8'd69; cycles(2);
        tag = "R6"; vsup = 8'd100; cycles(1);
        vsup = 8'd109; cycles(1);
        vsup = 8'd110; cycles(2);
        vsup = 8'd80; cycles(1);
        // R7: bad transfers
        tag = "R7";
        strobe(0); cycles(1); strobe(0); strobe(0); cycles(1);
        strobe(0); cycles(2);
        strobe(0); strobe(0); strobe(0);
        // R8: valid without strobe is ignored, then a good transfer
        tag = "R8";
        link_valid = 1'b1; cycles(2); link_valid = 1'b0;
        strobe(1); cycles(1);
        strobe(0); strobe(0); strobe(0); strobe(1); cycles(1);
        // R9: input domain not stable
        tag = "R9";
        input_stable = 1'b0; set_temp(5, 140); cycles(2);
        set_temp(5, 130); cycles(1);
        input_stable = 1'b1; cycles(2);
        set_temp(5, 120); cycles(1);
        // R4: diag ignores link failure
        tag = "R4";
        strobe(0); strobe(0); strobe(0); strobe(0); cycles(1);
        strobe(1);
        // mixed random run across all requirements
        tag = "R10";
        for (int n = 0; n < 3000; n++) begin
            cmd = 8'($urandom);
            for (int i = 0; i < NCH; i++)
                if ($urandom_range(0, 7) == 0) set_temp(i, 120 + $urandom_range(0, 20));
            if ($urandom_range(0, 15) == 0) vsup = 8'(60 + $urandom_range(0, 60));
            link_strobe = ($urandom_range(0, 3) == 0);
            link_valid  = ($urandom_range(0, 2) != 0);
            input_stable = ($urandom_range(0, 19) != 0);
            cyc();
        end
        link_strobe = 1'b0;
        // R1: reset again mid-run
        tag = "R1";
        rst = 1'b1; cycles(2); rst = 1'b0; cycles(1);
        finish_run();
    end

endmodule